// File: doc/BRIEF.md
# Multibit Trie Node Index Unit

This unit does the index arithmetic for one node of a multibit trie search that walks an address four bits per step. A search engine gives it the current slice of the destination address (the nibble) and the fields of the node it has just fetched: a 16-bit map of which child branches exist, a 15-bit map of the prefixes stored inside the node, and two 18-bit base pointers. The child-array base points to the node's children, which are stored contiguously. The hop-table base points to the node's next-hop entries, which are also stored contiguously.

From these inputs the unit finds four results. It reports whether the nibble leads to a child. It gives the memory address of that child. It gives the position of the longest stored prefix inside the node that matches the nibble. It gives the address of the next-hop entry for that prefix. Each address is a base pointer plus a count of set bitmap bits before the selected position. The count is added only to the low four bits of the base. The carry out of that small add chooses between the upper pointer bits and a precomputed increment of them.

Results are registered one cycle after a qualified input. Memory access and search sequencing belong to the engine that uses the unit.

Top module: `tbm_node_index`

## Requirements
- R1: While synchronous reset `rst` is high, at the next rising edge `out_valid`, `child_ok`, `child_addr`, `pfx_idx` and `hop_addr` all become zero.
- R2: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high, and low after an edge at which `in_valid` was low.
- R3: `child_ok` reports bit `ext_bmp[15 - nibble]`. Nibble value n selects position n of the child map, where positions are counted from the most significant bit.
- R4: `child_addr` equals `child_base` plus the number of set bits in child-map positions 0 to n-1, which are bits `ext_bmp[15 : 16-n]`. For example, map 0x5490 with nibble 8 adds 3.
- R5: Prefix-map position p is bit `int_bmp[14 - p]`. Position 0 holds the zero-length prefix, positions 1-2 hold the one-bit prefixes, positions 3-6 the two-bit prefixes and positions 7-14 the three-bit prefixes. For length L, the candidate position is (2^L - 1) + (nibble >> (4 - L)).
- R6: `pfx_idx` is the candidate position of the greatest length L whose bit is set. It is 15 when no candidate bit is set.
- R7: `hop_addr` equals `hop_base` plus the number of set bits in prefix-map positions 0 to `pfx_idx`-1. When `pfx_idx` is 15, this is the count of all set bits in `int_bmp`.
- R8: Both address sums are exact modulo 2^18. A carry out of the low four bits reaches the upper bits, and a sum past 0x3FFFF wraps to zero.
- R9: After an edge at which `in_valid` was low, `child_ok`, `child_addr`, `pfx_idx` and `hop_addr` keep their previous values, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the node fields and nibble this cycle |
| nibble | input | 4 | Current address slice |
| ext_bmp | input | 16 | Child-existence map, position 0 at the MSB |
| int_bmp | input | 15 | Stored-prefix map, ordered by prefix length |
| child_base | input | 18 | Base pointer of the child array |
| hop_base | input | 18 | Base pointer of the next-hop table |
| out_valid | output | 1 | Registered results are fresh |
| child_ok | output | 1 | A child exists for this nibble |
| child_addr | output | 18 | Address of the selected child |
| pfx_idx | output | 4 | Position of the longest matching prefix, 15 if none |
| hop_addr | output | 18 | Address of the next-hop entry |

## Verification
The child path and the next-hop path run in parallel from the same inputs, so both split adders can carry in the same cycle. The bench provokes this with base pointers whose low nibble sits at 0xC to 0xF, with full or dense bitmaps, and with an all-ones base that must wrap to zero. Each of the two addresses is then compared with a plain full-width sum of base and count. Every nibble is swept against each bitmap pair, so a miscount on either side, or a carry that arrives at the wrong address, shows up independently of the other path.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  localparam int STRIDE_DEF = 4;
  localparam int PTR_W_DEF  = 18;

  // first bitmap position of the prefixes of length lvl
  function automatic int level_base(input int lvl);
    return (1 << lvl) - 1;
  endfunction
endpackage

// File: rtl/tbm_left_ones.sv
module tbm_left_ones #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 4
) (
  input  logic [WIDTH-1:0] bmp,
  input  logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] cnt
);
  logic [WIDTH-1:0] masked;

  // element i is the bitmap position i counted from the MSB
  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign masked[i] = bmp[WIDTH-1-i] & (i < int'(pos));
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < WIDTH; i++) begin
      cnt = cnt + CNT_W'(masked[i]);
    end
  end
endmodule

// File: rtl/tbm_prefix_search.sv
module tbm_prefix_search
  import tbm_pkg::*;
#(
  parameter int STRIDE = 4,
  localparam int INT_W = (1 << STRIDE) - 1
) (
  input  logic [STRIDE-1:0] nibble,
  input  logic [INT_W-1:0]  bmp,
  output logic [STRIDE-1:0] idx
);
  logic [STRIDE-1:0] lvl_pos [STRIDE];
  logic [STRIDE-1:0] lvl_hit;

  for (genvar l = 0; l < STRIDE; l++) begin : g_lvl
    localparam int BASE = level_base(l);
    assign lvl_pos[l] = STRIDE'(BASE) + (nibble >> (STRIDE - l));
    assign lvl_hit[l] = bmp[(INT_W - 1) - int'(lvl_pos[l])];
  end

  // deeper levels overwrite shallower ones
  always_comb begin
    idx = '1;
    for (int l = 0; l < STRIDE; l++) begin
      if (lvl_hit[l]) idx = lvl_pos[l];
    end
  end
endmodule

// File: rtl/tbm_split_add.sv
module tbm_split_add #(
  parameter int PTR_W = 18,
  parameter int LOW_W = 4,
  localparam int HI_W = PTR_W - LOW_W
) (
  input  logic [PTR_W-1:0] base,
  input  logic [LOW_W-1:0] off,
  output logic [PTR_W-1:0] sum
);
  logic [LOW_W:0]  low_sum;
  logic [HI_W-1:0] hi_keep;
  logic [HI_W-1:0] hi_inc;

  assign low_sum = {1'b0, base[LOW_W-1:0]} + {1'b0, off};
  assign hi_keep = base[PTR_W-1:LOW_W];
  assign hi_inc  = hi_keep + HI_W'(1);
  assign sum     = {(low_sum[LOW_W] ? hi_inc : hi_keep), low_sum[LOW_W-1:0]};
endmodule

// File: rtl/tbm_node_index.sv
module tbm_node_index
  import tbm_pkg::*;
#(
  parameter int STRIDE = STRIDE_DEF,
  parameter int PTR_W  = PTR_W_DEF,
  localparam int EXT_W = 1 << STRIDE,
  localparam int INT_W = (1 << STRIDE) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [STRIDE-1:0] nibble,
  input  logic [EXT_W-1:0]  ext_bmp,
  input  logic [INT_W-1:0]  int_bmp,
  input  logic [PTR_W-1:0]  child_base,
  input  logic [PTR_W-1:0]  hop_base,
  output logic              out_valid,
  output logic              child_ok,
  output logic [PTR_W-1:0]  child_addr,
  output logic [STRIDE-1:0] pfx_idx,
  output logic [PTR_W-1:0]  hop_addr
);
  logic [STRIDE-1:0] child_cnt;
  logic [STRIDE-1:0] best_pos;
  logic [STRIDE-1:0] hop_cnt;
  logic [PTR_W-1:0]  child_sum;
  logic [PTR_W-1:0]  hop_sum;
  logic              child_bit;

  assign child_bit = ext_bmp[(EXT_W - 1) - int'(nibble)];

  tbm_left_ones #(.WIDTH(EXT_W), .CNT_W(STRIDE)) u_child_cnt (
    .bmp(ext_bmp), .pos(nibble), .cnt(child_cnt)
  );

  tbm_split_add #(.PTR_W(PTR_W), .LOW_W(STRIDE)) u_child_add (
    .base(child_base), .off(child_cnt), .sum(child_sum)
  );

  tbm_prefix_search #(.STRIDE(STRIDE)) u_search (
    .nibble(nibble), .bmp(int_bmp), .idx(best_pos)
  );

  tbm_left_ones #(.WIDTH(INT_W), .CNT_W(STRIDE)) u_hop_cnt (
    .bmp(int_bmp), .pos(best_pos), .cnt(hop_cnt)
  );

  tbm_split_add #(.PTR_W(PTR_W), .LOW_W(STRIDE)) u_hop_add (
    .base(hop_base), .off(hop_cnt), .sum(hop_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      child_ok   <= 1'b0;
      child_addr <= '0;
      pfx_idx    <= '0;
      hop_addr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        child_ok   <= child_bit;
        child_addr <= child_sum;
        pfx_idx    <= best_pos;
        hop_addr   <= hop_sum;
      end
    end
  end
endmodule

// File: rtl/tbm_node_index_chk.sv
module tbm_node_index_chk #(
  parameter int STRIDE = 4,
  parameter int PTR_W  = 18,
  localparam int EXT_W = 1 << STRIDE,
  localparam int INT_W = (1 << STRIDE) - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [STRIDE-1:0] nibble,
  input logic [EXT_W-1:0]  ext_bmp,
  input logic [INT_W-1:0]  int_bmp,
  input logic [PTR_W-1:0]  child_base,
  input logic [PTR_W-1:0]  hop_base,
  input logic              out_valid,
  input logic              child_ok,
  input logic [PTR_W-1:0]  child_addr,
  input logic [STRIDE-1:0] pfx_idx,
  input logic [PTR_W-1:0]  hop_addr
);
  logic sel_bit;
  assign sel_bit = ext_bmp[(EXT_W - 1) - int'(nibble)];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !child_ok && child_addr == '0 && hop_addr == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(child_addr) && $stable(hop_addr)
                   && $stable(pfx_idx) && $stable(child_ok)));

  // R3
  child_flag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> child_ok == $past(sel_bit));

  // R4
  child_span_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> PTR_W'(child_addr - $past(child_base)) < PTR_W'(EXT_W));

  // R7
  hop_span_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> PTR_W'(hop_addr - $past(hop_base)) < PTR_W'(EXT_W));

  // R6
  no_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int_bmp == '0) |=> (pfx_idx == STRIDE'(INT_W) && hop_addr == $past(hop_base)));

  // R6
  root_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int_bmp[INT_W-1]) |=> pfx_idx != STRIDE'(INT_W));
endmodule

bind tbm_node_index tbm_node_index_chk #(.STRIDE(STRIDE), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .nibble(nibble),
  .ext_bmp(ext_bmp), .int_bmp(int_bmp), .child_base(child_base),
  .hop_base(hop_base), .out_valid(out_valid), .child_ok(child_ok),
  .child_addr(child_addr), .pfx_idx(pfx_idx), .hop_addr(hop_addr)
);

// File: tb/tbm_node_index_tb_top.sv
module tbm_node_index_tb_top;
  localparam int PW   = 18;
  localparam int MASK = (1 << PW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [3:0]    nibble = '0;
  logic [15:0]   ext_bmp = '0;
  logic [14:0]   int_bmp = '0;
  logic [PW-1:0] child_base = '0;
  logic [PW-1:0] hop_base = '0;
  logic          out_valid;
  logic          child_ok;
  logic [PW-1:0] child_addr;
  logic [3:0]    pfx_idx;
  logic [PW-1:0] hop_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int unsigned seed = 32'h1234_5677;

  always #4 clk = ~clk;

  tbm_node_index #(.STRIDE(4), .PTR_W(PW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .nibble(nibble),
    .ext_bmp(ext_bmp), .int_bmp(int_bmp), .child_base(child_base),
    .hop_base(hop_base), .out_valid(out_valid), .child_ok(child_ok),
    .child_addr(child_addr), .pfx_idx(pfx_idx), .hop_addr(hop_addr)
  );

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic int pc(input int v);
    int c = 0;
    for (int b = 0; b < 32; b++) c += (v >> b) & 1;
    return c;
  endfunction

  function automatic int ref_pfx(input int n, input int ib);
    for (int l = 3; l >= 0; l--) begin
      int p = (1 << l) - 1 + (n >> (4 - l));
      if (((ib >> (14 - p)) & 1) == 1) return p;
    end
    return 15;
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive one vector, then check the registered results one cycle later
  task automatic run_vec(input int n, input int eb, input int ib,
                         input int cb, input int hb, input string tag);
    int p, ccnt, hcnt, cexp, hexp;
    @(negedge clk);
    in_valid   = 1'b1;
    nibble     = 4'(n);
    ext_bmp    = 16'(eb);
    int_bmp    = 15'(ib);
    child_base = PW'(cb);
    hop_base   = PW'(hb);
    @(negedge clk);
    in_valid = 1'b0;
    ccnt = (n == 0) ? 0 : pc((eb & 16'hFFFF) >> (16 - n));
    p    = ref_pfx(n, ib & 16'h7FFF);
    hcnt = (p == 0) ? 0 : pc((ib & 16'h7FFF) >> (15 - p));
    cexp = (cb + ccnt) & MASK;
    hexp = (hb + hcnt) & MASK;
    check_eq({tag, " R2 out_valid"}, int'(out_valid), 1);
    check_eq({tag, " R3 child_ok"}, int'(child_ok), (eb >> (15 - n)) & 1);
    check_eq({tag, " R4 R8 child_addr"}, int'(child_addr), cexp);
    check_eq({tag, " R5 R6 pfx_idx"}, int'(pfx_idx), p);
    check_eq({tag, " R7 R8 hop_addr"}, int'(hop_addr), hexp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int keep_c, keep_h, keep_p, keep_k;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_eq("R1 out_valid", int'(out_valid), 0);
    check_eq("R1 child_ok", int'(child_ok), 0);
    check_eq("R1 child_addr", int'(child_addr), 0);
    check_eq("R1 pfx_idx", int'(pfx_idx), 0);
    check_eq("R1 hop_addr", int'(hop_addr), 0);

    // R4 R5 R6 R7: worked node, child index 3, prefix position 5, hop offset 2
    run_vec(8, 16'h5490, 15'h4602, 18'h00100, 18'h00200, "example");
    check_eq("R4 example child", int'(child_addr), 18'h00103);
    check_eq("R6 example pfx", int'(pfx_idx), 5);
    check_eq("R7 example hop", int'(hop_addr), 18'h00202);

    // R6: empty prefix map gives 15 and the bare hop base
    run_vec(3, 16'h0000, 15'h0000, 18'h00040, 18'h00777, "empty");
    check_eq("R6 empty pfx", int'(pfx_idx), 15);

    // R8: both adders carry in the same cycle and wrap past the top
    run_vec(15, 16'hFFFF, 15'h7FFF, 18'h3FFFF, 18'h3FFFC, "wrap");
    check_eq("R8 child wrap", int'(child_addr), 18'h0000E);
    check_eq("R8 hop wrap", int'(hop_addr), 18'h0000A);

    // R9: inputs change with in_valid low, outputs must hold
    keep_c = int'(child_addr);
    keep_h = int'(hop_addr);
    keep_p = int'(pfx_idx);
    keep_k = int'(child_ok);
    @(negedge clk);
    nibble = 4'd0; ext_bmp = 16'h0000; int_bmp = 15'h0000;
    child_base = 18'h12345; hop_base = 18'h2ABCD;
    @(negedge clk);
    check_eq("R2 idle out_valid", int'(out_valid), 0);
    check_eq("R9 hold child_addr", int'(child_addr), keep_c);
    check_eq("R9 hold hop_addr", int'(hop_addr), keep_h);
    check_eq("R9 hold pfx_idx", int'(pfx_idx), keep_p);
    check_eq("R9 hold child_ok", int'(child_ok), keep_k);

    // sweep every nibble over many bitmap pairs and base pointers
    for (int s = 0; s < 300; s++) begin
      int eb = int'(rnd() & 32'hFFFF);
      int ib = int'(rnd() & 32'h7FFF);
      int cb = int'(rnd()) & MASK;
      int hb = int'(rnd()) & MASK;
      if (s % 7 == 0) ib = 0;
      if (s % 11 == 0) eb = 16'hFFFF;
      if (s % 2 == 0) begin
        cb = cb | 12;
        hb = hb | 12;
      end
      for (int n = 0; n < 16; n++) begin
        run_vec(n, eb, ib, cb, hb, "sweep");
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule